// File: doc/BRIEF.md
# Folded Lifting Wavelet Engine (one shared multiply-add unit)

This block runs a one-dimensional lifting wavelet transform on a stream of sample pairs. A single multiply-add unit does all the work. It computes `result = anchor + F * (A + C)`, using one multiplier and two adders. A phase counter reuses this unit for every predict and update step. For each step, the counter picks the operands and a fixed-point coefficient. Each step's result is fed back through history registers so that later steps and the next pair can use it.

The parameter `IS_97` picks the transform:

- `IS_97 = 1`: the long-filter transform, with four steps per pair (predict, update, predict, update).
- `IS_97 = 0`: the short-filter transform, with two steps per pair (predict, update).

Samples enter as an even/odd pair over a valid/ready handshake. Results leave as an approximation/detail pair over a valid/ready handshake.

Back-pressure rules:

- A pair is taken on any clock edge where `in_valid` and `in_ready` are both high.
- A result is consumed on any edge where `out_valid` and `out_ready` are both high.
- While a result waits for the consumer, the engine holds in its last phase and takes no new pair.
- A source should hold its pair until it is accepted. The block does not look at data that is not accepted.

Top module: `lift_folded_dwt`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) does three things. It clears all history registers to zero, sets `out_valid` low and returns the phase counter to phase 0, so `in_ready` reads high.
- R2: `in_ready` is high only in phase 0. In phase 0 the counter waits until `in_valid` is high, and then takes the pair on that edge. From any middle phase it moves to the next phase on every clock.
- R3: With `in_valid` held high and the output never blocked, a pair is accepted every N cycles. N is 4 when `IS_97=1` and 2 when `IS_97=0`.
- R4: A pair accepted at clock edge t produces its result registered at edge t+N-1, provided the output slot is free. `out_valid` goes high after that edge.
- R5: Each step computes `anchor + ((F*(A+C) + 8192) >>> 14)` in two's complement on IW = SAMPLE_W+GUARD_W bits. F is a signed 16-bit coefficient with 14 fraction bits, so the product is rounded to nearest with ties toward plus infinity.
- R6: With `IS_97=0`, write the pair index as k and e, o for the even and odd samples. Then:
  - `d(k-1) = o(k-1) + rnd(-8192, e(k-1)+e(k))`
  - `s(k-1) = e(k-1) + rnd(4096, d(k-2)+d(k-1))`
  - The output pair after pair k is (s(k-1), d(k-1)).
- R7: With `IS_97=1`, the four steps run in this order:
  - a predict with -25987, giving a
  - an update with -868, giving b
  - a predict with 14466, giving c
  - an update with 7266, giving s
  
  The operand rule for each step:
  - The first step uses o(k-1) as its anchor, with e(k-1) and e(k) as its pair.
  - Each later step uses as its anchor the previous pair's result from two steps earlier.
  - Its pair is that step's previous result together with the newest result of the step before it.
  
  The output after pair k is approximation s(k-2) and detail c(k-2).
- R8: All history (samples and step results of earlier pairs) reads as zero after reset. So the first outputs after a reset are computed as if every earlier sample were zero.
- R9: While `out_valid` is high and `out_ready` is low, three things hold. `out_approx` and `out_detail` stay stable, the engine does not leave its last phase, and `in_ready` stays low.
- R10: When a result is consumed and no new result is registered on the same edge, `out_valid` drops after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair is present |
| in_ready | output | 1 | Engine takes a pair (phase 0) |
| in_even | input | SAMPLE_W | Even sample, signed |
| in_odd | input | SAMPLE_W | Odd sample, signed |
| out_valid | output | 1 | Result pair is present |
| out_ready | input | 1 | Consumer takes the result |
| out_approx | output | SAMPLE_W+GUARD_W | Approximation (low-pass) coefficient, signed |
| out_detail | output | SAMPLE_W+GUARD_W | Detail (high-pass) coefficient, signed |

## Verification
A pair taken at edge t must show up at the outputs after edge t+N-1. This is three edges later for the long filter and one edge later for the short filter. If the consumer blocks, the result instead appears one edge after the blocking result is taken. The bench keeps a behavioural model of each configuration that is advanced once per clock from the same handshake inputs. It then compares `in_ready`, `out_valid` and the result pair against the model at every falling edge, so a result that comes one cycle early or late is flagged in the cycle it differs. Two instances, one per transform, are driven with the same stimulus. A separate window counts accepted pairs to confirm the issue rate.

// File: rtl/lift_pkg.sv
package lift_pkg;

  localparam int COEF_W  = 16;
  localparam int COEF_FB = 14;

  // Lifting coefficients in signed Q2.14, indexed by step number.
  function automatic logic signed [COEF_W-1:0] step_coef(input bit is97, input int unsigned step);
    logic signed [COEF_W-1:0] c;
    if (is97) begin
      case (step)
        0:       c = -16'sd25987;
        1:       c = -16'sd868;
        2:       c = 16'sd14466;
        default: c = 16'sd7266;
      endcase
    end else begin
      case (step)
        0:       c = -16'sd8192;
        default: c = 16'sd4096;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/lift_pe.sv
module lift_pe
  import lift_pkg::*;
#(
  parameter int IW = 20
) (
  input  logic [IW-1:0]     anchor,
  input  logic [IW-1:0]     opa,
  input  logic [IW-1:0]     opc,
  input  logic [COEF_W-1:0] coef,
  output logic [IW-1:0]     result
);
  localparam int PW = IW + 1 + COEF_W;

  logic signed [IW:0]   pair_sum;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic                 round_bit;

  // first adder: symmetric pair
  assign pair_sum = $signed({opa[IW-1], opa}) + $signed({opc[IW-1], opc});
  // the single multiplier
  assign prod     = pair_sum * $signed(coef);
  assign scaled   = prod >>> COEF_FB;
  assign round_bit = prod[COEF_FB-1];
  // second adder: anchor plus scaled product, rounding as carry-in
  assign result   = anchor + IW'(scaled) + IW'(round_bit);

endmodule

// File: rtl/lift_seq.sv
module lift_seq #(
  parameter int NSTEPS = 4,
  localparam int STW = $clog2(NSTEPS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           out_blocked,
  output logic [STW-1:0] state,
  output logic           adv,
  output logic           in_ready,
  output logic           last_fire
);
  localparam logic [STW-1:0] LAST = STW'(NSTEPS - 1);

  always_comb begin
    if (state == '0)        adv = in_valid;
    else if (state == LAST) adv = !out_blocked;
    else                    adv = 1'b1;
  end

  assign in_ready  = (state == '0);
  assign last_fire = adv && (state == LAST);

  always_ff @(posedge clk) begin
    if (rst)             state <= '0;
    else if (last_fire)  state <= '0;
    else if (adv)        state <= state + STW'(1);
  end

  assert_mid_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state != '0 && state != LAST) |=> state == $past(state) + STW'(1));

  assert_idle_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (state == '0 && !in_valid) |=> state == '0);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (state == LAST && !out_blocked) |=> state == '0);

  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (state == LAST && out_blocked) |=> state == LAST);

endmodule

// File: rtl/lift_opmux.sv
module lift_opmux
  import lift_pkg::*;
#(
  parameter bit IS_97 = 1'b1,
  parameter int IW = 20,
  localparam int NSTEPS = IS_97 ? 4 : 2,
  localparam int STW = $clog2(NSTEPS),
  localparam int HN = NSTEPS - 1
) (
  input  logic [STW-1:0]         state,
  input  logic [IW-1:0]          in_even_x,
  input  logic [IW-1:0]          odd_prev,
  input  logic [IW-1:0]          even_prev,
  input  logic [HN-1:0][IW-1:0]  hist,
  input  logic [IW-1:0]          res1,
  output logic [IW-1:0]          anchor,
  output logic [IW-1:0]          opa,
  output logic [IW-1:0]          opc,
  output logic [COEF_W-1:0]      coef
);

  assign coef = step_coef(IS_97, int'(state));

  generate
    if (IS_97) begin : g_four
      always_comb begin
        case (state)
          2'd0: begin anchor = odd_prev;  opa = even_prev; opc = in_even_x; end
          2'd1: begin anchor = even_prev; opa = hist[0];   opc = res1;      end
          2'd2: begin anchor = hist[0];   opa = hist[1];   opc = res1;      end
          default: begin anchor = hist[1]; opa = hist[2];  opc = res1;      end
        endcase
      end
    end else begin : g_two
      always_comb begin
        if (state == 1'b0) begin
          anchor = odd_prev;  opa = even_prev; opc = in_even_x;
        end else begin
          anchor = even_prev; opa = hist[0];   opc = res1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lift_hist.sv
module lift_hist #(
  parameter int NSTEPS = 4,
  parameter int IW = 20,
  localparam int STW = $clog2(NSTEPS),
  localparam int HN = NSTEPS - 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic [STW-1:0]        state,
  input  logic [IW-1:0]         in_even_x,
  input  logic [IW-1:0]         in_odd_x,
  input  logic [IW-1:0]         pe_out,
  output logic [IW-1:0]         odd_prev,
  output logic [IW-1:0]         even_prev,
  output logic [HN-1:0][IW-1:0] hist,
  output logic [IW-1:0]         res1
);
  localparam logic [STW-1:0] LAST = STW'(NSTEPS - 1);

  logic [IW-1:0] even_cur;

  // sample history and latest step result
  always_ff @(posedge clk) begin
    if (rst) begin
      odd_prev  <= '0;
      even_prev <= '0;
      even_cur  <= '0;
      res1      <= '0;
    end else if (adv) begin
      res1 <= pe_out;
      if (state == '0) begin
        odd_prev <= in_odd_x;
        even_cur <= in_even_x;
      end
      if (state == STW'(1)) even_prev <= even_cur;
    end
  end

  // last step-result history: written in the final phase from the newest result
  logic [IW-1:0] tail_q;
  always_ff @(posedge clk) begin
    if (rst)                          tail_q <= '0;
    else if (adv && state == LAST)    tail_q <= res1;
  end
  assign hist[HN-1] = tail_q;

  // earlier step-result history, written two phases after its step
  generate
    if (NSTEPS > 2) begin : g_deep
      logic [IW-1:0] res2;
      always_ff @(posedge clk) begin
        if (rst)      res2 <= '0;
        else if (adv) res2 <= res1;
      end
      for (genvar m = 0; m < NSTEPS - 2; m++) begin : g_h
        logic [IW-1:0] h_q;
        always_ff @(posedge clk) begin
          if (rst)                                h_q <= '0;
          else if (adv && state == STW'(m + 2))   h_q <= res2;
        end
        assign hist[m] = h_q;
      end
    end
  endgenerate

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(res1) && $stable(odd_prev) && $stable(even_prev) && $stable(hist)));

  assert_odd_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && state == '0) |=> odd_prev == $past(in_odd_x));

endmodule

// File: rtl/lift_folded_dwt.sv
module lift_folded_dwt
  import lift_pkg::*;
#(
  parameter bit IS_97    = 1'b1,
  parameter int SAMPLE_W = 16,
  parameter int GUARD_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [SAMPLE_W-1:0]           in_even,
  input  logic [SAMPLE_W-1:0]           in_odd,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [SAMPLE_W+GUARD_W-1:0]   out_approx,
  output logic [SAMPLE_W+GUARD_W-1:0]   out_detail
);
  localparam int NSTEPS = IS_97 ? 4 : 2;
  localparam int STW    = $clog2(NSTEPS);
  localparam int IW     = SAMPLE_W + GUARD_W;
  localparam int HN     = NSTEPS - 1;
  localparam logic [STW-1:0] LAST = STW'(NSTEPS - 1);

  logic [STW-1:0]        state;
  logic                  adv, last_fire, out_blocked;
  logic [IW-1:0]         in_even_x, in_odd_x;
  logic [IW-1:0]         odd_prev, even_prev, res1;
  logic [HN-1:0][IW-1:0] hist;
  logic [IW-1:0]         anchor, opa, opc, pe_out;
  logic [COEF_W-1:0]     coef;

  assign in_even_x   = {{GUARD_W{in_even[SAMPLE_W-1]}}, in_even};
  assign in_odd_x    = {{GUARD_W{in_odd[SAMPLE_W-1]}}, in_odd};
  assign out_blocked = out_valid && !out_ready;

  lift_seq #(.NSTEPS(NSTEPS)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_blocked(out_blocked),
    .state(state), .adv(adv), .in_ready(in_ready), .last_fire(last_fire)
  );

  lift_opmux #(.IS_97(IS_97), .IW(IW)) u_mux (
    .state(state), .in_even_x(in_even_x), .odd_prev(odd_prev),
    .even_prev(even_prev), .hist(hist), .res1(res1),
    .anchor(anchor), .opa(opa), .opc(opc), .coef(coef)
  );

  lift_pe #(.IW(IW)) u_pe (
    .anchor(anchor), .opa(opa), .opc(opc), .coef(coef), .result(pe_out)
  );

  lift_hist #(.NSTEPS(NSTEPS), .IW(IW)) u_hist (
    .clk(clk), .rst(rst), .adv(adv), .state(state),
    .in_even_x(in_even_x), .in_odd_x(in_odd_x), .pe_out(pe_out),
    .odd_prev(odd_prev), .even_prev(even_prev), .hist(hist), .res1(res1)
  );

  // output slot: final update is the approximation, final predict the detail
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_approx <= '0;
      out_detail <= '0;
    end else if (last_fire) begin
      out_valid  <= 1'b1;
      out_approx <= pe_out;
      out_detail <= res1;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_approx) && $stable(out_detail)));

  assert_rise_after_last_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(state) == LAST);

  assert_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !last_fire) |=> !out_valid);

endmodule

// File: tb/test_lift_folded_dwt.sv
`timescale 1ns/1ps

module dwt_scoreboard #(
  parameter bit IS_97 = 1'b1,
  parameter int IW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [15:0]   in_even,
  input logic [15:0]   in_odd,
  input logic          out_ready,
  input logic          dut_in_ready,
  input logic          dut_out_valid,
  input logic [IW-1:0] dut_approx,
  input logic [IW-1:0] dut_detail
);
  localparam int N = IS_97 ? 4 : 2;
  int checks = 0;
  int errors = 0;
  int ph = 0;
  bit ov = 0;
  bit first_out = 1;
  longint oa = 0, od = 0, pa = 0, pd = 0;
  longint o_prev = 0, e_prev = 0, h_a = 0, h_b = 0, h_c = 0;

  function automatic longint rnd(input longint c, input longint s);
    return (c * s + 8192) >>> 14;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d t=%0t", tag, IS_97 ? "long" : "short", act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    automatic bit adv;
    automatic longint e, o, a, b, c, s;
    // compare with model
    check(dut_in_ready == (ph == 0), rst ? "R1 in_ready" : ((ph == N-1 && ov) ? "R9 in_ready" : "R2 in_ready"),
          longint'(dut_in_ready), longint'(ph == 0));
    check(dut_out_valid == ov, rst ? "R1 out_valid" : "R4/R10 out_valid", longint'(dut_out_valid), longint'(ov));
    if (ov && dut_out_valid) begin
      check($signed(dut_approx) == oa, first_out ? "R8 approx" : (IS_97 ? "R5/R7 approx" : "R5/R6 approx"),
            longint'($signed(dut_approx)), oa);
      check($signed(dut_detail) == od, first_out ? "R8 detail" : (IS_97 ? "R5/R7 detail" : "R5/R6 detail"),
            longint'($signed(dut_detail)), od);
    end
    // advance model to next edge
    if (rst) begin
      ph = 0; ov = 0; first_out = 1;
      o_prev = 0; e_prev = 0; h_a = 0; h_b = 0; h_c = 0;
    end else begin
      if (ph == 0)        adv = in_valid;
      else if (ph == N-1) adv = !ov || out_ready;
      else                adv = 1;
      if (ov && out_ready) first_out = 0;
      if (ph == 0 && in_valid) begin
        e = longint'($signed(in_even));
        o = longint'($signed(in_odd));
        if (IS_97) begin
          a = o_prev + rnd(-25987, e_prev + e);
          b = e_prev + rnd(-868, h_a + a);
          c = h_a + rnd(14466, h_b + b);
          s = h_b + rnd(7266, h_c + c);
          h_a = a; h_b = b; h_c = c;
          pa = s; pd = c;
        end else begin
          a = o_prev + rnd(-8192, e_prev + e);
          s = e_prev + rnd(4096, h_a + a);
          h_a = a;
          pa = s; pd = a;
        end
        o_prev = o; e_prev = e;
      end
      if (ph == N-1 && adv) begin
        ov = 1; oa = pa; od = pd;
      end else if (ov && out_ready) begin
        ov = 0;
      end
      if (adv) ph = (ph == N-1) ? 0 : ph + 1;
    end
  end
endmodule

module test_lift_folded_dwt;
  localparam int IW = 20;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic out_ready = 1;
  logic [15:0] in_even = '0;
  logic [15:0] in_odd = '0;
  logic rdy97, ov97, rdy53, ov53;
  logic [IW-1:0] ap97, dt97, ap53, dt53;

  int top_checks = 0;
  int top_errors = 0;
  int cyc = 0;
  bit win = 0;
  int acc97 = 0, acc53 = 0;

  always #10 clk = ~clk;

  lift_folded_dwt #(.IS_97(1'b1)) i_lift_folded_dwt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy97),
    .in_even(in_even), .in_odd(in_odd), .out_valid(ov97), .out_ready(out_ready),
    .out_approx(ap97), .out_detail(dt97)
  );

  lift_folded_dwt #(.IS_97(1'b0)) i_lift_folded_dwt_short (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy53),
    .in_even(in_even), .in_odd(in_odd), .out_valid(ov53), .out_ready(out_ready),
    .out_approx(ap53), .out_detail(dt53)
  );

  dwt_scoreboard #(.IS_97(1'b1), .IW(IW)) sb97 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_even(in_even), .in_odd(in_odd),
    .out_ready(out_ready), .dut_in_ready(rdy97), .dut_out_valid(ov97),
    .dut_approx(ap97), .dut_detail(dt97)
  );

  dwt_scoreboard #(.IS_97(1'b0), .IW(IW)) sb53 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_even(in_even), .in_odd(in_odd),
    .out_ready(out_ready), .dut_in_ready(rdy53), .dut_out_valid(ov53),
    .dut_approx(ap53), .dut_detail(dt53)
  );

  // issue-rate window (R3)
  always @(negedge clk) begin
    if (win) begin
      if (in_valid && rdy97) acc97++;
      if (in_valid && rdy53) acc53++;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", sb97.checks + sb53.checks + top_checks,
             sb97.errors + sb53.errors + top_errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      top_checks++;
      top_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic step(input bit v, input bit r, input int ev, input int od);
    @(posedge clk);
    #2;
    in_valid  = v;
    out_ready = r;
    in_even   = 16'(ev);
    in_odd    = 16'(od);
  endtask

  function automatic int rs();
    return int'($urandom_range(4094)) - 2047;
  endfunction

  initial begin
    // R1: reset held for several edges
    rst = 1;
    repeat (4) step(0, 1, 0, 0);
    rst = 0;
    // R3: continuous input, free output, window aligned to phase 0
    win = 1;
    for (int i = 0; i < 40; i++) step(1, 1, rs(), rs());
    win = 0;
    top_checks++;
    if (acc97 != 10) begin
      top_errors++;
      $display("FAIL R3 long accepts actual=%0d expected=%0d", acc97, 10);
    end
    top_checks++;
    if (acc53 != 20) begin
      top_errors++;
      $display("FAIL R3 short accepts actual=%0d expected=%0d", acc53, 20);
    end
    // R2/R4: sparse valid
    for (int i = 0; i < 200; i++) step(($urandom_range(1) == 1), 1, rs(), rs());
    // R9/R10: random back-pressure
    for (int i = 0; i < 200; i++) step(($urandom_range(2) != 0), ($urandom_range(4) > 1), rs(), rs());
    // R9: long stall with valid high
    for (int i = 0; i < 12; i++) step(1, 0, rs(), rs());
    for (int i = 0; i < 20; i++) step(1, 1, rs(), rs());
    // R1/R8: reset mid-stream, then an impulse on zero history
    rst = 1;
    repeat (3) step(1, 1, 0, 0);
    rst = 0;
    step(1, 1, 1000, 0);
    for (int i = 0; i < 30; i++) step(1, 1, 0, 0);
    // R6/R7: extreme values
    for (int i = 0; i < 24; i++) step(1, 1, (i % 2 == 0) ? 2047 : -2048, (i % 3 == 0) ? -2048 : 2047);
    step(0, 1, 0, 0);
    repeat (10) step(0, 1, 0, 0);
    finish_run();
  end

endmodule